// File: doc/BRIEF.md
# Reversible-Gate Carry-Skip Adder/Subtractor

This block adds or subtracts two WIDTH-bit operands (default 4) with a carry/borrow input. A single mode input chooses the operation, so the same hardware serves both. It is purely combinational. Every bit cell is assembled only from three reversible primitives:

- a controlled-swap gate;
- a double fan-out XOR gate;
- a four-input AND-XOR gate.

Each cell ties some gate inputs to constants, and the gate outputs it does not use leave the block as garbage bits.

The cells pass the carry/borrow along as a ripple chain. Each cell also produces a bit propagate. A skip network ANDs the bit propagates into a block propagate. When the block propagate is set, it steers the incoming carry/borrow directly to the block output and the ripple result is not used. The skip network is also built from controlled-swap gates.

Top module: `rcs_skip_adsub`

## Requirements
- R1: With `sub_i`=0, {`cout_o`,`res_o`} equals `a_i`+`b_i`+`cin_i`, taken as unsigned (WIDTH+1)-bit arithmetic.
- R2: With `sub_i`=1, `res_o` equals (`a_i`−`b_i`−`cin_i`) modulo 2^WIDTH. `cout_o` is 1 exactly when `a_i` < `b_i`+`cin_i`, which is a borrow out.
- R3: `bprop_o` is 1 exactly when every bit position propagates. A bit propagates when `a_i[n]`⊕`b_i[n]` is 1 in add mode, and when `a_i[n]`⊕`b_i[n]` is 0 in subtract mode.
- R4: Whenever `bprop_o` is 1, `cout_o` equals `cin_i`. The skip path and the ripple chain never disagree.
- R5: Controlled-swap primitive with inputs (a,b,c) and outputs (p,q,r):
  - p=a;
  - q=b when a=0 and q=c when a=1;
  - r=c when a=0 and r=b when a=1;
  - the XOR of the outputs equals the XOR of the inputs.
- R6: Double fan-out primitive with inputs (a,b,c) and outputs (p,q,r):
  - p=a, q=a⊕b, r=a⊕c;
  - the XOR of the outputs equals the XOR of the inputs.
- R7: AND-XOR primitive with inputs (a,b,c,d) and outputs (p,q,r,s): p=a, q=a⊕b, r=(a∧b)⊕c, s=(a∧b)⊕d.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend in subtract mode) |
| b_i | input | WIDTH | Second operand (subtrahend in subtract mode) |
| cin_i | input | 1 | Carry-in (add) or borrow-in (subtract) |
| sub_i | input | 1 | Mode: 0 adds, 1 subtracts |
| res_o | output | WIDTH | Sum or difference |
| cout_o | output | 1 | Carry-out (add) or borrow-out (subtract) |
| bprop_o | output | 1 | Block propagate: all bit positions propagate |
| junk_o | output | 7*WIDTH+1 | Unused reversible-gate outputs (garbage) |

## Verification
No register lies on any path, so every output is due in the same cycle as its stimulus. The bench applies each operand, carry and mode combination just after a rising edge and samples the result at the following falling edge. By then the combinational network has settled, and no edge lies between stimulus and sample. The 512 operand/carry combinations are run in each mode against an integer reference. Each primitive is also instantiated alone and driven through its complete truth table with the same timing.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } rcs_op_e;

  // carry rule after the minuend has been conditioned by the mode bit:
  // generate when both are set, pass the incoming bit when they differ
  function automatic logic carry_rule(logic x, logic b, logic c);
    return (x & b) | (c & (x ^ b));
  endfunction

  function automatic logic bit_propagates(logic a, logic b, rcs_op_e op);
    return (op == OP_SUB) ? ~(a ^ b) : (a ^ b);
  endfunction

endpackage

// File: rtl/rv_cswap.sv
module rv_cswap (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign p_o = a_i;
  assign q_o = (~a_i & b_i) ^ (a_i & c_i);
  assign r_o = (~a_i & c_i) ^ (a_i & b_i);

  always_comb begin
    assert_swap_parity_R5: assert ((p_o ^ q_o ^ r_o) == (a_i ^ b_i ^ c_i))
      else $error("swap gate parity broken");
    assert_swap_weight_R5: assert ($countones({p_o, q_o, r_o}) == $countones({a_i, b_i, c_i}))
      else $error("swap gate changed ones count");
  end
endmodule

// File: rtl/rv_dfan.sv
module rv_dfan (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign p_o = a_i;
  assign q_o = a_i ^ b_i;
  assign r_o = a_i ^ c_i;

  always_comb begin
    assert_fan_parity_R6: assert ((p_o ^ q_o ^ r_o) == (a_i ^ b_i ^ c_i))
      else $error("fan-out gate parity broken");
  end
endmodule

// File: rtl/rv_andxor.sv
module rv_andxor (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  output logic p_o,
  output logic q_o,
  output logic r_o,
  output logic s_o
);
  logic both;
  assign both = a_i & b_i;
  assign p_o  = a_i;
  assign q_o  = a_i ^ b_i;
  assign r_o  = both ^ c_i;
  assign s_o  = both ^ d_i;

  always_comb begin
    // with the control low the last two lines are untouched
    if (!a_i) begin
      assert_andxor_pass_R7: assert (r_o == c_i && s_o == d_i && q_o == b_i)
        else $error("and-xor gate disturbed lines with control low");
    end
    assert_andxor_twin_R7: assert ((r_o ^ s_o) == (c_i ^ d_i))
      else $error("and-xor gate twin outputs diverged");
  end
endmodule

// File: rtl/rcs_cell.sv
module rcs_cell
  import rcs_pkg::*;
#(
  parameter  int CELL_JUNK = 5
) (
  input  logic                 a_i,
  input  logic                 b_i,
  input  logic                 c_i,
  input  logic                 m_i,
  output logic                 s_o,
  output logic                 c_o,
  output logic                 p_o,
  output logic [CELL_JUNK-1:0] junk_o
);
  // stage 1: condition the minuend by the mode, keep mode and its inverse
  logic m_pass, x_cond, m_inv;
  rv_dfan u_fan (
    .a_i(m_i), .b_i(a_i), .c_i(1'b1),
    .p_o(m_pass), .q_o(x_cond), .r_o(m_inv)
  );

  // stage 2: bit propagate and generate
  logic x_left, prop, gen, gen_dup;
  rv_andxor u_pg (
    .a_i(x_cond), .b_i(b_i), .c_i(1'b0), .d_i(1'b0),
    .p_o(x_left), .q_o(prop), .r_o(gen), .s_o(gen_dup)
  );

  // stage 3: carry/borrow out and the half-result
  logic prop_out, half, carry, pc_left;
  rv_andxor u_cy (
    .a_i(prop), .b_i(c_i), .c_i(gen), .d_i(1'b0),
    .p_o(prop_out), .q_o(half), .r_o(carry), .s_o(pc_left)
  );

  // stage 4: remove the mode bit from the half-result with a swap
  logic half_left, res, res_inv;
  rv_cswap u_fix (
    .a_i(half), .b_i(m_pass), .c_i(m_inv),
    .p_o(half_left), .q_o(res), .r_o(res_inv)
  );

  assign s_o    = res;
  assign c_o    = carry;
  assign p_o    = prop_out;
  assign junk_o = {res_inv, half_left, pc_left, gen_dup, x_left};

  always_comb begin
    if (p_o) begin
      assert_cell_pass_R4: assert (c_o == c_i)
        else $error("propagating cell did not pass carry");
    end
    assert_cell_sum_R1: assert (s_o == (a_i ^ b_i ^ c_i))
      else $error("cell result bit wrong");
    assert_cell_carry_R2: assert (c_o == carry_rule(a_i ^ m_i, b_i, c_i))
      else $error("cell carry/borrow wrong");
  end
endmodule

// File: rtl/rcs_skip.sv
module rcs_skip #(
  parameter  int WIDTH   = 4,
  localparam int JUNK_W  = 2 * WIDTH + 1
) (
  input  logic [WIDTH-1:0]  prop_i,
  input  logic              cin_i,
  input  logic              rip_i,
  output logic              cout_o,
  output logic              bp_o,
  output logic [JUNK_W-1:0] junk_o
);
  logic [WIDTH:0] acc;
  assign acc[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    logic ctl_left, mix_left;
    rv_cswap u_and (
      .a_i(acc[i]), .b_i(prop_i[i]), .c_i(1'b0),
      .p_o(ctl_left), .q_o(mix_left), .r_o(acc[i+1])
    );
    assign junk_o[2*i]   = ctl_left;
    assign junk_o[2*i+1] = mix_left;
  end

  logic sel_left;
  rv_cswap u_mux (
    .a_i(acc[WIDTH]), .b_i(rip_i), .c_i(cin_i),
    .p_o(bp_o), .q_o(cout_o), .r_o(sel_left)
  );
  assign junk_o[JUNK_W-1] = sel_left;

  always_comb begin
    if (bp_o) begin
      assert_skip_bypass_R4: assert (cout_o == cin_i)
        else $error("skip path did not forward carry-in");
    end else begin
      assert_skip_ripple_R4: assert (cout_o == rip_i)
        else $error("ripple carry not selected");
    end
  end
endmodule

// File: rtl/rcs_skip_adsub.sv
module rcs_skip_adsub #(
  parameter  int WIDTH     = 4,
  localparam int CELL_JUNK = 5,
  localparam int SKIP_JUNK = 2 * WIDTH + 1,
  localparam int JUNK_W    = CELL_JUNK * WIDTH + SKIP_JUNK
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [WIDTH-1:0]  res_o,
  output logic              cout_o,
  output logic              bprop_o,
  output logic [JUNK_W-1:0] junk_o
);
  import rcs_pkg::*;

  function automatic logic [WIDTH:0] ref_addsub(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b,
                                                logic c, logic s);
    logic [WIDTH:0] w;
    if (!s) w = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c};
    else    w = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, c};
    return w;
  endfunction

  logic [WIDTH:0]             chain;
  logic [WIDTH-1:0]           prop;
  logic [CELL_JUNK*WIDTH-1:0] cell_junk;
  logic [SKIP_JUNK-1:0]       skip_junk;
  logic                       ripple_cout;
  logic                       skip_taken;

  assign chain[0] = cin_i;

  for (genvar n = 0; n < WIDTH; n++) begin : g_cell
    rcs_cell #(.CELL_JUNK(CELL_JUNK)) u_cell (
      .a_i(a_i[n]), .b_i(b_i[n]), .c_i(chain[n]), .m_i(sub_i),
      .s_o(res_o[n]), .c_o(chain[n+1]), .p_o(prop[n]),
      .junk_o(cell_junk[n*CELL_JUNK +: CELL_JUNK])
    );
  end

  assign ripple_cout = chain[WIDTH];

  rcs_skip #(.WIDTH(WIDTH)) u_skip (
    .prop_i(prop), .cin_i(cin_i), .rip_i(ripple_cout),
    .cout_o(cout_o), .bp_o(bprop_o), .junk_o(skip_junk)
  );

  assign skip_taken = bprop_o;
  assign junk_o     = {skip_junk, cell_junk};

  always_comb begin
    assert_skip_match_R4: assert (cout_o == ripple_cout)
      else $error("skip output differs from ripple output");
    if (sub_i == OP_ADD) begin
      assert_add_result_R1: assert ({cout_o, res_o} == ref_addsub(a_i, b_i, cin_i, 1'b0))
        else $error("sum wrong");
    end else begin
      assert_sub_result_R2: assert ({cout_o, res_o} == ref_addsub(a_i, b_i, cin_i, 1'b1))
        else $error("difference wrong");
    end
    if (skip_taken) begin
      assert_bprop_bits_R3: assert (&prop)
        else $error("block propagate without all bit propagates");
    end
  end
endmodule

// File: tb/rcs_skip_adsub_tb.sv
module rcs_skip_adsub_tb;
  localparam int W  = 4;
  localparam int JW = 7 * W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  logic [W-1:0]  a, b, res;
  logic          cin, sub, cout, bprop;
  logic [JW-1:0] junk;

  rcs_skip_adsub #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .cin_i(cin), .sub_i(sub),
    .res_o(res), .cout_o(cout), .bprop_o(bprop), .junk_o(junk)
  );

  // standalone primitives
  logic ga, gb, gc, gd;
  logic sw_p, sw_q, sw_r, fn_p, fn_q, fn_r, ax_p, ax_q, ax_r, ax_s;
  rv_cswap  u_swp (.a_i(ga), .b_i(gb), .c_i(gc), .p_o(sw_p), .q_o(sw_q), .r_o(sw_r));
  rv_dfan   u_fan (.a_i(ga), .b_i(gb), .c_i(gc), .p_o(fn_p), .q_o(fn_q), .r_o(fn_r));
  rv_andxor u_axr (.a_i(ga), .b_i(gb), .c_i(gc), .d_i(gd),
                   .p_o(ax_p), .q_o(ax_q), .r_o(ax_r), .s_o(ax_s));

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0; sub = 1'b0;
    ga = 1'b0; gb = 1'b0; gc = 1'b0; gd = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle state: all-zero inputs in add mode give zero result, no carry, propagate clear
    @(negedge clk);
    check(res == 0 && cout == 1'b0, "R1 idle", {cout, res}, 0);
    check(bprop == 1'b0, "R3 idle", bprop, 0);

    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 512; v++) begin
        int ai, bi, ci, full, eres, ecout;
        bit ebp;
        ai = v & 15;
        bi = (v >> 4) & 15;
        ci = (v >> 8) & 1;
        @(posedge clk);
        #1;
        a = ai[W-1:0]; b = bi[W-1:0]; cin = ci[0]; sub = m[0];
        if (m == 0) begin
          full  = ai + bi + ci;
          eres  = full % 16;
          ecout = (full >= 16) ? 1 : 0;
        end else begin
          full  = ai - bi - ci;
          eres  = (full + 32) % 16;
          ecout = (full < 0) ? 1 : 0;
        end
        ebp = 1'b1;
        for (int k = 0; k < W; k++) begin
          bit same;
          same = (((ai >> k) & 1) == ((bi >> k) & 1));
          if (m == 0 && same)  ebp = 1'b0;
          if (m == 1 && !same) ebp = 1'b0;
        end
        @(negedge clk);
        if (m == 0)
          check(int'(res) == eres && int'(cout) == ecout, "R1 add",
                int'({cout, res}), ecout * 16 + eres);
        else
          check(int'(res) == eres && int'(cout) == ecout, "R2 sub",
                int'({cout, res}), ecout * 16 + eres);
        check(bprop == ebp, "R3 bprop", bprop, ebp);
        if (ebp)
          check(cout == cin, "R4 skip", cout, cin);
      end
    end

    for (int v = 0; v < 16; v++) begin
      bit xa, xb, xc, xd;
      xa = v[0]; xb = v[1]; xc = v[2]; xd = v[3];
      @(posedge clk);
      #1;
      ga = xa; gb = xb; gc = xc; gd = xd;
      @(negedge clk);
      if (v < 8) begin
        int eq, er;
        eq = xa ? xc : xb;
        er = xa ? xb : xc;
        check(sw_p == xa && int'(sw_q) == eq && int'(sw_r) == er, "R5 swap map",
              int'({sw_p, sw_q, sw_r}), xa * 4 + eq * 2 + er);
        check((sw_p ^ sw_q ^ sw_r) == (xa ^ xb ^ xc), "R5 swap parity",
              sw_p ^ sw_q ^ sw_r, xa ^ xb ^ xc);
        check(fn_p == xa && fn_q == (xa ^ xb) && fn_r == (xa ^ xc), "R6 fan map",
              int'({fn_p, fn_q, fn_r}), xa * 4 + (xa ^ xb) * 2 + (xa ^ xc));
        check((fn_p ^ fn_q ^ fn_r) == (xa ^ xb ^ xc), "R6 fan parity",
              fn_p ^ fn_q ^ fn_r, xa ^ xb ^ xc);
      end
      begin
        int e;
        e = xa * 8 + (xa ^ xb) * 4 + ((xa & xb) ^ xc) * 2 + ((xa & xb) ^ xd);
        check(int'({ax_p, ax_q, ax_r, ax_s}) == e, "R7 and-xor map",
              int'({ax_p, ax_q, ax_r, ax_s}), e);
      end
    end

    finish_run();
  end
endmodule